// File: doc/BRIEF.md
# Card Clock Generator with Quarter-Phase Taps

This block produces the card clock of an SD/eMMC host controller together with three phase-shifted copies of it, one for driving the command line, one for launching transmit data and one for sampling receive data. Both candidate source clocks reach the block as single-cycle tick strobes in the host clock domain: a slow tick from the fixed 24 MHz reference and a fast tick from the system clock. The block divides the selected tick stream by a programmable integer. Internally it counts quarter periods, so each tap can be delayed by 0, 1, 2 or 3 quarters of the card clock period.

Software supplies a 14-bit clock word that holds the divisor, the source select and the three phase fields. It also drives separate controls for freezing the clock, for idle-gating it, for forcing it on and for double-data-rate sampling. Settings are copied into an active set only at the start of a card clock period, which is the start of its low half. While the freeze control is set, no copy is made at all. A gated or frozen clock always finishes its current period and then rests low, so a settings change never produces a shortened pulse.

Top module: `card_clk_gen`

## Requirements
- R1: While reset is asserted and right after it, card_clk, cmd_clk, tx_clk, rx_clk and ddr_both_edges are all 0.
- R2: With divisor field D (clk_cfg[5:0]), the quarter length is Q = ceil(D/4), and D = 0 gives Q = 1. card_clk is low for 2Q source ticks and then high for 2Q source ticks, with each period starting in its low half.
- R3: A source field (clk_cfg[7:6]) of 1 counts fast_tick. The values 0, 2 and 3 count ref_tick.
- R4: A phase field of value k makes its tap equal to card_clk delayed by k*Q source ticks. cmd_clk uses clk_cfg[9:8], tx_clk uses clk_cfg[11:10] and rx_clk uses clk_cfg[13:12].
- R5: While stop_clk is 1, card_clk finishes its current period, then stays low and does not toggle, and changes to clk_cfg are ignored. Once stop_clk returns to 0, the then-current clk_cfg is applied from the next period.
- R6: A clk_cfg change made in the middle of a period does not alter the remainder of that period. It takes effect from the next period boundary, which is the falling edge of card_clk.
- R7: When auto_gate is 1, always_on is 0 and xfer_busy is 0, card_clk parks low. It runs when xfer_busy is 1, when always_on is 1, or when auto_gate is 0.
- R8: ddr_both_edges follows ddr_req, but it updates only at a period boundary, together with the other settings.
- R9: The largest divisor, 63, gives Q = 16 and a period of 64 source ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference source cycle |
| fast_tick | input | 1 | One-cycle strobe per fast source cycle |
| clk_cfg | input | 14 | Divisor [5:0], source [7:6], command phase [9:8], transmit phase [11:10], receive phase [13:12] |
| stop_clk | input | 1 | Freeze request: park the clock and block settings updates |
| auto_gate | input | 1 | Enables idle gating of the clock |
| always_on | input | 1 | Overrides idle gating |
| ddr_req | input | 1 | Requests double-edge data sampling |
| xfer_busy | input | 1 | A transfer is in progress |
| card_clk | output | 1 | Divided card clock |
| cmd_clk | output | 1 | Command-output phase copy |
| tx_clk | output | 1 | Transmit phase copy |
| rx_clk | output | 1 | Receive sampling phase copy |
| ddr_both_edges | output | 1 | Active double-edge sampling flag |

## Verification
The bench measures the low and high lengths of card_clk for divisors across the quantisation steps: 0, 1, the odd values 5, 7 and 13, the multiples of four and 63, all through both tick sources. A design that rounded down, or that treated divisor 0 literally, would show halves that are too short or a clock that never moves. It changes the divisor and the DDR request in the middle of a high half and checks both the remainder of that half and the next low half; a design that applied settings at once would cut the pulse short. It checks that a frozen or idle-gated clock rests low and ignores writes made during the freeze. It compares each tap against a delayed copy of card_clk, which catches taps with swapped phase fields or delays in the wrong direction.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;
  localparam int DIV_W  = 6;
  localparam int SRC_W  = 2;
  localparam int PH_W   = 2;
  localparam int Q_W    = DIV_W - 1;
  localparam int CFG_W  = DIV_W + SRC_W + 3 * PH_W;
  localparam int N_TAPS = 4;

  typedef struct packed {
    logic             ddr;
    logic [PH_W-1:0]  rx_ph;
    logic [PH_W-1:0]  tx_ph;
    logic [PH_W-1:0]  cmd_ph;
    logic [SRC_W-1:0] src;
    logic [DIV_W-1:0] div;
  } ccg_set_t;

  // Split the clock word into fields and attach the double-edge request.
  function automatic ccg_set_t unpack_cfg(input logic [CFG_W-1:0] w, input logic ddr);
    ccg_set_t s;
    s.div    = w[DIV_W-1:0];
    s.src    = w[DIV_W +: SRC_W];
    s.cmd_ph = w[DIV_W+SRC_W +: PH_W];
    s.tx_ph  = w[DIV_W+SRC_W+PH_W +: PH_W];
    s.rx_ph  = w[DIV_W+SRC_W+2*PH_W +: PH_W];
    s.ddr    = ddr;
    return s;
  endfunction

  // Quarter period in source ticks: ceil(div/4), with a minimum of one.
  function automatic logic [Q_W-1:0] quarter_len(input logic [DIV_W-1:0] d);
    logic [DIV_W:0] t;
    t = {1'b0, d} + (DIV_W+1)'(3);
    if (d == '0) return Q_W'(1);
    return t[DIV_W:2];
  endfunction

  // Level of a tap delayed by 'sh' quarters when the phase counter is at 'ph'.
  function automatic logic tap_level(input logic [PH_W-1:0] ph, input logic [PH_W-1:0] sh);
    logic [PH_W-1:0] d;
    d = ph - sh;
    return d[PH_W-1];
  endfunction

  function automatic logic src_is_fast(input logic [SRC_W-1:0] s);
    return s == SRC_W'(1);
  endfunction
endpackage

// File: rtl/ccg_src_sel.sv
`timescale 1ns/1ps
module ccg_src_sel
  import ccg_pkg::*;
(
  input  logic             ref_tick,
  input  logic             fast_tick,
  input  logic [SRC_W-1:0] src,
  output logic             tick
);
  always_comb begin
    tick = src_is_fast(src) ? fast_tick : ref_tick;
  end
endmodule

// File: rtl/ccg_gate_ctl.sv
`timescale 1ns/1ps
module ccg_gate_ctl
  import ccg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ccg_set_t cfg_set,
  input  logic     stop_clk,
  input  logic     auto_gate,
  input  logic     always_on,
  input  logic     xfer_busy,
  input  logic     at_boundary,
  output logic     gate_run,
  output logic     load_en,
  output ccg_set_t act,
  output ccg_set_t eff
);
  logic want_idle_gate;

  always_comb begin
    want_idle_gate = auto_gate && !always_on && !xfer_busy;
    gate_run       = !stop_clk && !want_idle_gate;
    load_en        = at_boundary && !stop_clk;
    eff            = load_en ? cfg_set : act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act <= '0;
    else if (load_en) act <= cfg_set;
  end

  // R5: a frozen clock takes no new settings
  a_r5_stop_freezes_settings: assert property (@(posedge clk) disable iff (!rst_n)
    stop_clk |=> $stable(act));
  // R6: settings move only at the start of a period
  a_r6_update_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !at_boundary |=> $stable(act));
endmodule

// File: rtl/ccg_phase_ctr.sv
`timescale 1ns/1ps
module ccg_phase_ctr
  import ccg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [Q_W-1:0]  q_len,
  input  logic            gate_run,
  output logic [PH_W-1:0] ph,
  output logic            at_boundary
);
  logic [Q_W-1:0] qcnt;
  logic           parked;
  logic           step;
  logic           q_wrap;

  always_comb begin
    at_boundary = (ph == '0) && (qcnt == '0);
    parked      = at_boundary && !gate_run;
    step        = tick && !parked;
    q_wrap      = (qcnt == Q_W'(q_len - Q_W'(1)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt <= '0;
      ph   <= '0;
    end else if (step) begin
      if (q_wrap) begin
        qcnt <= '0;
        ph   <= ph + PH_W'(1);
      end else begin
        qcnt <= qcnt + Q_W'(1);
      end
    end
  end

  // R2: the quarter counter never passes the quarter length
  a_r2_qcnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    qcnt < q_len);
  // R2: the phase moves only on a source tick
  a_r2_move_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(ph) && $stable(qcnt)));
  // R5, R7: a gated clock stays parked at the boundary
  a_r7_park_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (at_boundary && !gate_run) |=> at_boundary);
endmodule

// File: rtl/ccg_phase_taps.sv
`timescale 1ns/1ps
module ccg_phase_taps
  import ccg_pkg::*;
#(
  parameter int TAPS = N_TAPS
) (
  input  logic [PH_W-1:0]           ph,
  input  logic [TAPS-1:0][PH_W-1:0] shift,
  output logic [TAPS-1:0]           lvl
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    always_comb lvl[i] = tap_level(ph, shift[i]);
  end
endmodule

// File: rtl/card_clk_gen.sv
`timescale 1ns/1ps
module card_clk_gen
  import ccg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             fast_tick,
  input  logic [CFG_W-1:0] clk_cfg,
  input  logic             stop_clk,
  input  logic             auto_gate,
  input  logic             always_on,
  input  logic             ddr_req,
  input  logic             xfer_busy,
  output logic             card_clk,
  output logic             cmd_clk,
  output logic             tx_clk,
  output logic             rx_clk,
  output logic             ddr_both_edges
);
  ccg_set_t                   cfg_set, act, eff;
  logic                       gate_run, load_en, at_boundary, tick;
  logic [PH_W-1:0]            ph;
  logic [Q_W-1:0]             q_len;
  logic [N_TAPS-1:0][PH_W-1:0] shifts;
  logic [N_TAPS-1:0]          lvl;

  always_comb begin
    cfg_set = unpack_cfg(clk_cfg, ddr_req);
    q_len   = quarter_len(eff.div);
    shifts  = {act.rx_ph, act.tx_ph, act.cmd_ph, PH_W'(0)};
  end

  ccg_gate_ctl u_gate (
    .clk(clk), .rst_n(rst_n), .cfg_set(cfg_set), .stop_clk(stop_clk),
    .auto_gate(auto_gate), .always_on(always_on), .xfer_busy(xfer_busy),
    .at_boundary(at_boundary), .gate_run(gate_run), .load_en(load_en),
    .act(act), .eff(eff)
  );

  ccg_src_sel u_src (
    .ref_tick(ref_tick), .fast_tick(fast_tick), .src(eff.src), .tick(tick)
  );

  ccg_phase_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(tick), .q_len(q_len),
    .gate_run(gate_run), .ph(ph), .at_boundary(at_boundary)
  );

  ccg_phase_taps #(.TAPS(N_TAPS)) u_taps (
    .ph(ph), .shift(shifts), .lvl(lvl)
  );

  assign card_clk       = lvl[0];
  assign cmd_clk        = lvl[1];
  assign tx_clk         = lvl[2];
  assign rx_clk         = lvl[3];
  assign ddr_both_edges = act.ddr;

  // R6: each period begins low
  a_r6_period_starts_low: assert property (@(posedge clk) disable iff (!rst_n)
    at_boundary |-> !card_clk);
  // R5: a frozen and parked clock does not move
  a_r5_frozen_static: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_clk && at_boundary) |=> $stable(card_clk));
  // R8: the double-edge flag changes only where settings load
  a_r8_ddr_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(ddr_both_edges));
endmodule

// File: tb/sim_card_clk_gen.sv
`timescale 1ns/1ps
module sim_card_clk_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0, fast_tick = 1'b1;
  logic [13:0] clk_cfg = '0;
  logic stop_clk = 1'b0, auto_gate = 1'b0, always_on = 1'b0, ddr_req = 1'b0, xfer_busy = 1'b0;
  logic card_clk, cmd_clk, tx_clk, rx_clk, ddr_both_edges;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  card_clk_gen u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fast_tick(fast_tick),
    .clk_cfg(clk_cfg), .stop_clk(stop_clk), .auto_gate(auto_gate),
    .always_on(always_on), .ddr_req(ddr_req), .xfer_busy(xfer_busy),
    .card_clk(card_clk), .cmd_clk(cmd_clk), .tx_clk(tx_clk), .rx_clk(rx_clk),
    .ddr_both_edges(ddr_both_edges)
  );

  // Reference strobe: one host cycle in three.
  initial begin
    int rc = 0;
    forever begin
      @(negedge clk);
      rc++;
      ref_tick = (rc % 3 == 0);
    end
  end

  // Vector table: divisor, source, expected half length in host cycles.
  localparam int NV = 9;
  localparam int V_DIV [NV] = '{0, 1, 5, 8, 63, 4, 7, 13, 12};
  localparam int V_SRC [NV] = '{1, 1, 1, 1, 1, 0, 2, 3, 1};
  localparam int V_HALF[NV] = '{2, 2, 4, 4, 32, 6, 12, 24, 6};

  task automatic chk(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_len(output int n);
    logic v;
    v = card_clk;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (card_clk == v && n < 3000);
  endtask

  task automatic wait_fall();
    int n;
    if (card_clk == 1'b0) run_len(n);
    run_len(n);
  endtask

  task automatic count_toggles(input int cycles, output int t);
    logic v;
    v = card_clk;
    t = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (card_clk != v) t++;
      v = card_clk;
    end
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int lo, hi, t, mism_c, mism_t, mism_r;
    logic [63:0] h;
    clk_cfg = {6'd0, 2'd1, 6'd4};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", card_clk, 0, "card_clk in reset");
    chk("R1", cmd_clk | tx_clk | rx_clk, 0, "taps in reset");
    chk("R1", ddr_both_edges, 0, "ddr in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", card_clk, 0, "card_clk after reset");

    // R2, R3, R9: table of divisors and sources
    for (int i = 0; i < NV; i++) begin
      clk_cfg = {6'd0, 2'(V_SRC[i]), 6'(V_DIV[i])};
      wait_fall();
      run_len(lo);
      run_len(hi);
      chk(V_DIV[i] == 63 ? "R9" : (V_SRC[i] == 1 ? "R2" : "R3"), lo, V_HALF[i], $sformatf("low half div=%0d src=%0d", V_DIV[i], V_SRC[i]));
      chk(V_DIV[i] == 63 ? "R9" : (V_SRC[i] == 1 ? "R2" : "R3"), hi, V_HALF[i], $sformatf("high half div=%0d src=%0d", V_DIV[i], V_SRC[i]));
    end

    // R4: taps are card_clk delayed by k quarters (div 8, Q=2, fast)
    clk_cfg = {2'd3, 2'd2, 2'd1, 2'd1, 6'd8};
    wait_fall();
    wait_fall();
    h = '0;
    repeat (16) begin
      @(negedge clk);
      h = {h[62:0], card_clk};
    end
    mism_c = 0; mism_t = 0; mism_r = 0;
    repeat (40) begin
      @(negedge clk);
      if (cmd_clk != h[1]) mism_c++;
      if (tx_clk  != h[3]) mism_t++;
      if (rx_clk  != h[5]) mism_r++;
      h = {h[62:0], card_clk};
    end
    chk("R4", mism_c, 0, "cmd_clk mismatches vs 1 quarter delay");
    chk("R4", mism_t, 0, "tx_clk mismatches vs 2 quarter delay");
    chk("R4", mism_r, 0, "rx_clk mismatches vs 3 quarter delay");

    // R6, R8: mid-period change (div 16 -> 4)
    clk_cfg = {6'd0, 2'd1, 6'd16};
    wait_fall();
    run_len(lo);
    chk("R6", lo, 8, "low half div=16");
    repeat (2) @(negedge clk);
    clk_cfg = {6'd0, 2'd1, 6'd4};
    ddr_req = 1'b1;
    @(negedge clk);
    chk("R8", ddr_both_edges, 0, "ddr before boundary");
    run_len(hi);
    chk("R6", hi, 5, "remaining high after mid change");
    run_len(lo);
    chk("R6", lo, 2, "first low with new divisor");
    chk("R8", ddr_both_edges, 1, "ddr after boundary");

    // R5: freeze, change settings while frozen, release
    stop_clk = 1'b1;
    repeat (20) @(negedge clk);
    clk_cfg = {6'd0, 2'd1, 6'd12};
    ddr_req = 1'b0;
    chk("R5", card_clk, 0, "card_clk parked while stopped");
    count_toggles(30, t);
    chk("R5", t, 0, "toggles while stopped");
    chk("R5", ddr_both_edges, 1, "ddr unchanged while stopped");
    stop_clk = 1'b0;
    wait_fall();
    run_len(lo);
    run_len(hi);
    chk("R5", lo, 6, "low half after release");
    chk("R5", hi, 6, "high half after release");

    // R7: idle gating
    clk_cfg = {6'd0, 2'd1, 6'd4};
    auto_gate = 1'b1; always_on = 1'b0; xfer_busy = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7", card_clk, 0, "parked low when idle");
    count_toggles(30, t);
    chk("R7", t, 0, "toggles when idle");
    xfer_busy = 1'b1;
    count_toggles(20, t);
    chk("R7", t, 10, "toggles when busy");
    xfer_busy = 1'b0; always_on = 1'b1;
    count_toggles(20, t);
    chk("R7", t, 10, "toggles with always_on");
    always_on = 1'b0; auto_gate = 1'b0;
    count_toggles(20, t);
    chk("R7", t, 10, "toggles with gating disabled");

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule